// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block programs a contiguous range of bytes in a byte-wide flash array. The array is driven through its command register. For each address the block fetches the target byte from a valid/ready stream. It then runs attempts until the cell reads back correctly. Each attempt writes the program-setup command, writes the data byte (which opens a timed programming pulse), writes the program-verify command, waits for the cell to settle, and reads the byte back for comparison.

A mismatch starts another attempt at the same address, up to a hard cap of pulses. A match moves on to the next address. The high programming voltage is requested for the whole run and released on both outcomes. A successful run ends by writing the read-array command before reporting completion. A failed run captures the address that could not be programmed.

Bus strobe width, pulse length, verify settle time and the pulse cap are all parameters. At a 250 MHz clock the defaults give a 10 µs pulse and a 6 µs verify wait.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `bus_we`, `bus_re`, `in_ready`, `vpp_en`, `done`, `pass` and `fail` are all low.
- R2: A `start` seen while idle or finished latches the inclusive range `first_addr`..`last_addr` (first not above last). It raises `vpp_en` and takes one byte per address from the stream in ascending address order. `in_ready` is high only while a byte is awaited, and the byte is taken in the cycle where `in_valid` and `in_ready` are both high.
- R3: Each attempt drives, in order: a write strobe carrying 40h; a write strobe carrying the data byte; `PULSE_CYC` idle cycles; a write strobe carrying C0h; `VERIFY_CYC` idle cycles; a read strobe. Every strobe lasts exactly `STROBE_CYC` cycles, and `bus_addr` and `bus_wdata` hold the current address and value throughout it.
- R4: `bus_rdata` is compared with the expected byte in the last cycle of the read strobe. On a mismatch the next attempt for the same address starts in the next cycle, with no new stream fetch.
- R5: On a match that is not the last address, the pulse count clears, the address advances by one and the next byte is awaited in the next cycle.
- R6: An address gets at most `MAX_PULSES` (default 25) pulses. If the verify after the last allowed pulse mismatches, the block goes to `done`=1 and `fail`=1 with `vpp_en` low, and `fail_addr` holds the failing address.
- R7: When the last address matches, `vpp_en` drops and a write strobe carrying 00h is driven for `STROBE_CYC` cycles at that address. After it, `done`=1 and `pass`=1.
- R8: `done`, `pass` and `fail` hold until the next accepted `start`. A `start` during a run has no effect on any output.
- R9: `bus_we` and `bus_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle or finished) |
| first_addr | input | AW | First address of the range |
| last_addr | input | AW | Last address of the range (inclusive) |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Sequencer waiting for the next byte |
| in_data | input | 8 | Stream byte for the current address |
| bus_addr | output | AW | Array address |
| bus_wdata | output | 8 | Command or data byte written to the array |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 8 | Byte read from the array |
| vpp_en | output | 1 | Programming voltage request |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with every byte verified |
| fail | output | 1 | Run stopped on an unprogrammable byte |
| fail_addr | output | AW | Address that exhausted its pulses |

## Verification
The bench builds the block with `AW`=8, `STROBE_CYC`=2, `PULSE_CYC`=4, `VERIFY_CYC`=3, and keeps `MAX_PULSES` at 25. The short pulse and settle windows let a single byte run all 25 attempts in a few hundred cycles. That brings both sides of the cap within reach: a byte that verifies on exactly the 25th pulse and one that never does. A two-cycle strobe also exercises the hold of address and data across multi-cycle strobes and across back-to-back write commands.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_LATCH,
    ST_PULSE,
    ST_VSETUP,
    ST_VWAIT,
    ST_VREAD,
    ST_RDCMD,
    ST_PASS,
    ST_FAIL
  } fps_state_e;

  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PROG_VERIFY = 8'hC0;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'h00;

  // Number of cycles a phase occupies; untimed phases report one.
  function automatic int unsigned phase_len(fps_state_e s, int unsigned strobe,
                                            int unsigned pulse, int unsigned verify);
    case (s)
      ST_SETUP, ST_LATCH, ST_VSETUP, ST_VREAD, ST_RDCMD: phase_len = strobe;
      ST_PULSE:                                         phase_len = pulse;
      ST_VWAIT:                                         phase_len = verify;
      default:                                          phase_len = 1;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    max3 = (m > c) ? m : c;
  endfunction

  function automatic logic is_write_phase(fps_state_e s);
    return (s == ST_SETUP) || (s == ST_LATCH) || (s == ST_VSETUP) || (s == ST_RDCMD);
  endfunction

  function automatic logic is_hv_phase(fps_state_e s);
    return (s == ST_FETCH) || (s == ST_SETUP) || (s == ST_LATCH) || (s == ST_PULSE) ||
           (s == ST_VSETUP) || (s == ST_VWAIT) || (s == ST_VREAD);
  endfunction

  function automatic logic can_start(fps_state_e s);
    return (s == ST_IDLE) || (s == ST_PASS) || (s == ST_FAIL);
  endfunction

  // Byte placed on the bus in a given phase.
  function automatic logic [7:0] phase_wdata(fps_state_e s, logic [7:0] data);
    case (s)
      ST_SETUP:  phase_wdata = CMD_PROG_SETUP;
      ST_LATCH:  phase_wdata = data;
      ST_VSETUP: phase_wdata = CMD_PROG_VERIFY;
      default:   phase_wdata = CMD_READ_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/fps_phase_timer.sv
`timescale 1ns/1ps
module fps_phase_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fps_retry_counter.sv
`timescale 1ns/1ps
module fps_retry_counter #(
  parameter int unsigned MAX_PULSES = 25,
  parameter int unsigned CW         = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bump,
  output logic [CW-1:0] cnt,
  output logic          last_try
);

  localparam logic [CW-1:0] LAST = CW'(MAX_PULSES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt == LAST);

  // R6
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R6
  no_bump_at_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bump && last_try));

endmodule

// File: rtl/fps_addr_walker.sv
`timescale 1ns/1ps
module fps_addr_walker #(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic          step,
  output logic [AW-1:0] cur,
  output logic          at_last
);

  logic [AW-1:0] end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      end_q <= '0;
    end else if (load) begin
      cur   <= first;
      end_q <= last;
    end else if (step) begin
      cur   <= cur + 1'b1;
    end
  end

  assign at_last = (cur == end_q);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur == $past(cur) + 1'b1));

endmodule

// File: rtl/fps_bus_map.sv
`timescale 1ns/1ps
module fps_bus_map
  import fps_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  fps_state_e    state,
  input  logic [AW-1:0] cur_addr,
  input  logic [7:0]    data,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  output logic          in_ready,
  output logic          vpp_en,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  always_comb begin
    bus_addr  = cur_addr;
    bus_wdata = phase_wdata(state, data);
    bus_we    = is_write_phase(state);
    bus_re    = (state == ST_VREAD);
    in_ready  = (state == ST_FETCH);
    vpp_en    = is_hv_phase(state);
    pass      = (state == ST_PASS);
    fail      = (state == ST_FAIL);
    done      = pass || fail;
  end

endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int unsigned AW         = 17,
  parameter int unsigned STROBE_CYC = 4,
  parameter int unsigned PULSE_CYC  = 2500,
  parameter int unsigned VERIFY_CYC = 1500,
  parameter int unsigned MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [7:0]    bus_rdata,
  output logic          vpp_en,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);

  localparam int unsigned LONGEST = max3(STROBE_CYC, PULSE_CYC, VERIFY_CYC);
  localparam int unsigned TW      = $clog2(LONGEST + 1);
  localparam int unsigned CW      = $clog2(MAX_PULSES + 1);

  fps_state_e    state_q, state_d;
  logic [7:0]    data_q;
  logic [AW-1:0] fail_addr_q;
  logic [AW-1:0] cur_addr;
  logic          at_last;
  logic [CW-1:0] pulse_cnt;
  logic          last_try;
  logic          phase_expired;
  logic          timer_load;
  logic [TW-1:0] timer_val;

  // Named internal events
  logic start_ok, take_byte, verify_done, verify_match;
  logic byte_ok, byte_retry, byte_fail;

  assign start_ok     = start && can_start(state_q);
  assign take_byte    = (state_q == ST_FETCH) && in_valid;
  assign verify_done  = (state_q == ST_VREAD) && phase_expired;
  assign verify_match = (bus_rdata == data_q);
  assign byte_ok      = verify_done && verify_match;
  assign byte_retry   = verify_done && !verify_match && !last_try;
  assign byte_fail    = verify_done && !verify_match && last_try;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_PASS, ST_FAIL: if (start_ok)      state_d = ST_FETCH;
      ST_FETCH:                  if (take_byte)     state_d = ST_SETUP;
      ST_SETUP:                  if (phase_expired) state_d = ST_LATCH;
      ST_LATCH:                  if (phase_expired) state_d = ST_PULSE;
      ST_PULSE:                  if (phase_expired) state_d = ST_VSETUP;
      ST_VSETUP:                 if (phase_expired) state_d = ST_VWAIT;
      ST_VWAIT:                  if (phase_expired) state_d = ST_VREAD;
      ST_VREAD: begin
        if (byte_ok)         state_d = at_last ? ST_RDCMD : ST_FETCH;
        else if (byte_retry) state_d = ST_SETUP;
        else if (byte_fail)  state_d = ST_FAIL;
      end
      ST_RDCMD:                  if (phase_expired) state_d = ST_PASS;
      default:                   state_d = ST_IDLE;
    endcase
  end

  assign timer_load = (state_d != state_q);
  assign timer_val  = TW'(phase_len(state_d, STROBE_CYC, PULSE_CYC, VERIFY_CYC) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      data_q      <= '0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (take_byte) data_q      <= in_data;
      if (byte_fail) fail_addr_q <= cur_addr;
    end
  end

  assign fail_addr = fail_addr_q;

  fps_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (phase_expired)
  );

  fps_retry_counter #(.MAX_PULSES(MAX_PULSES), .CW(CW)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_ok || byte_ok),
    .bump     (byte_retry),
    .cnt      (pulse_cnt),
    .last_try (last_try)
  );

  fps_addr_walker #(.AW(AW)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_ok),
    .first   (first_addr),
    .last    (last_addr),
    .step    (byte_ok && !at_last),
    .cur     (cur_addr),
    .at_last (at_last)
  );

  fps_bus_map #(.AW(AW)) u_map (
    .state     (state_q),
    .cur_addr  (cur_addr),
    .data      (data_q),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .in_ready  (in_ready),
    .vpp_en    (vpp_en),
    .done      (done),
    .pass      (pass),
    .fail      (fail)
  );

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R3
  strobe_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && $past(bus_we || bus_re)) |-> $stable(bus_addr));

  // R2
  ready_under_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> vpp_en);

  // R4
  retry_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_retry |=> (bus_we && (bus_wdata == CMD_PROG_SETUP) && $stable(bus_addr)));

  // R6
  fail_drops_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!vpp_en && done));

  // R7
  read_cmd_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && at_last) |=> (bus_we && (bus_wdata == CMD_READ_ARRAY) && !vpp_en));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail)));

endmodule

// File: tb/tb_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_flash_prog_seq;

  localparam int AW = 8;
  localparam int SC = 2;
  localparam int PC = 4;
  localparam int VC = 3;
  localparam int MP = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic [7:0]    bus_rdata = '0;
  logic          in_ready, bus_we, bus_re, vpp_en, done, pass, fail;
  logic [AW-1:0] bus_addr, fail_addr;
  logic [7:0]    bus_wdata;

  always #2 clk = ~clk;

  flash_prog_seq #(.AW(AW), .STROBE_CYC(SC), .PULSE_CYC(PC), .VERIFY_CYC(VC),
                   .MAX_PULSES(MP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .last_addr(last_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .vpp_en(vpp_en),
    .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr));

  typedef struct packed {
    logic          we, re, rdy, vpp, dn, ps, fl;
    logic [7:0]    wd;
    logic [AW-1:0] ad;
    logic          iv;
    logic [7:0]    id, rd;
    logic [3:0]    tag;
  } rec_t;

  rec_t q[$];
  int total = 0;
  int bad = 0;
  int need [256];

  function automatic string tagname(int t);
    case (t)
      1: tagname = "R1"; 2: tagname = "R2"; 3: tagname = "R3";
      4: tagname = "R4"; 5: tagname = "R5"; 6: tagname = "R6";
      7: tagname = "R7"; 8: tagname = "R8"; default: tagname = "R9";
    endcase
  endfunction

  function automatic logic [7:0] val_of(int a);
    return 8'((a * 37 + 5) ^ 8'h5A);
  endfunction

  function automatic rec_t blank(int a, int t);
    rec_t r = '0;
    r.ad  = AW'(a);
    r.tag = 4'(t);
    return r;
  endfunction

  task automatic check(bit ok, int t, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tagname(t), what, act, exp);
    end
  endtask

  task automatic add(int n, rec_t r);
    for (int i = 0; i < n; i++) q.push_back(r);
  endtask

  // Behavioural reference: expected per-cycle bus activity for a run.
  task automatic build(int first, int last, int stall);
    rec_t r;
    for (int a = first; a <= last; a++) begin
      logic [7:0] v = val_of(a);
      int tries = (need[a] > MP) ? MP : need[a];
      r = blank(a, (a == first) ? 2 : 5);
      r.rdy = 1; r.vpp = 1;
      add(stall, r);
      r.iv = 1; r.id = v;
      add(1, r);
      for (int t = 1; t <= tries; t++) begin
        int tg = (t == 1) ? 3 : 4;
        rec_t w = blank(a, tg);
        rec_t idle = blank(a, tg);
        w.vpp = 1; w.we = 1; idle.vpp = 1;
        w.wd = 8'h40; add(SC, w);
        w.wd = v;     add(SC, w);
        add(PC, idle);
        w.wd = 8'hC0; add(SC, w);
        add(VC, idle);
        w.we = 0; w.re = 1; w.wd = 0;
        w.rd = (t >= need[a]) ? v : (v ^ 8'h80);
        add(SC, w);
      end
      if (need[a] > MP) begin
        r = blank(a, 6); r.dn = 1; r.fl = 1;
        add(1, r);
        r.tag = 8; add(3, r);
        return;
      end
    end
    r = blank(last, 7); r.we = 1; r.wd = 8'h00;
    add(SC, r);
    r = blank(last, 7); r.dn = 1; r.ps = 1;
    add(1, r);
    r.tag = 8; add(3, r);
  endtask

  task automatic run(int first, int last, int stall, bit intrude);
    int idx = 0;
    build(first, last, stall);
    @(negedge clk);
    start = 1; first_addr = AW'(first); last_addr = AW'(last);
    @(negedge clk);
    start = 0;
    while (q.size() > 0) begin
      rec_t r = q.pop_front();
      logic [6:0] act = {bus_we, bus_re, in_ready, vpp_en, done, pass, fail};
      logic [6:0] exp = {r.we, r.re, r.rdy, r.vpp, r.dn, r.ps, r.fl};
      check(act == exp, r.tag, "control", int'(act), int'(exp));
      if (r.we) begin
        check(bus_wdata == r.wd, r.tag, "wdata", int'(bus_wdata), int'(r.wd));
        check(bus_addr == r.ad, r.tag, "waddr", int'(bus_addr), int'(r.ad));
      end
      if (r.re) check(bus_addr == r.ad, r.tag, "raddr", int'(bus_addr), int'(r.ad));
      check(!(bus_we && bus_re), 9, "we_re_overlap", int'(bus_we && bus_re), 0);
      in_valid  = r.iv;
      in_data   = r.id;
      bus_rdata = r.rd;
      // R8: a start during the run must not disturb anything
      start = intrude && (idx == 10);
      if (start) first_addr = 8'hF0;
      idx++;
      @(negedge clk);
    end
    start = 0; in_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({bus_we, bus_re, in_ready, vpp_en, done, pass, fail} == 7'b0, 1, "reset outputs",
          int'({bus_we, bus_re, in_ready, vpp_en, done, pass, fail}), 0);
    rst_n = 1;
    @(negedge clk);
    check({bus_we, bus_re, in_ready, vpp_en, done, pass, fail} == 7'b0, 1, "idle outputs",
          int'({bus_we, bus_re, in_ready, vpp_en, done, pass, fail}), 0);

    need[5] = 3;
    run(4, 6, 0, 1'b1);

    need[10] = 2; need[11] = MP;
    run(10, 11, 2, 1'b0);

    need[21] = MP + 1;
    run(20, 21, 1, 1'b0);
    check(fail_addr == 8'd21, 6, "fail_addr", int'(fail_addr), 21);

    run(30, 30, 0, 1'b0);
    check(pass && !fail, 8, "restart after fail", int'({pass, fail}), 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule